// File: doc/BRIEF.md
# Encoded-Interval Watchdog Timer

This block is a watchdog whose timeout comes from a single configuration byte. The byte packs a two-bit resolution, a five-bit multiplier and a steering bit. The timeout is the multiplier times four to the power of the resolution, counted in sixteenths of a second. Those sixteenths arrive as single-cycle strobes on a tick input that is fed from a 16 Hz source outside the block.

Software services the watchdog by writing the configuration byte or by reading it back. Either access restarts the countdown from the interval that is then held and clears the timeout flag. If the countdown runs out, the flag is raised. The steering bit then decides what happens next. One choice wipes the configuration and asks for a system reset, which also tells the neighbouring calendar logic to drop its century-style bit. The other choice raises a single interrupt pulse.

Two reset inputs are kept apart. A power-on reset clears everything. A system reset only halts the countdown, so the configuration and the flag survive it.

Top module: `interval_watchdog`

## Requirements
- R1: The configuration byte decodes as resolution R = bits 1:0, multiplier M = bits 6:2 and steering bit = bit 7. After a restart, expiry is reached on the M×4^R-th tick and not before.
- R2: If the decoded interval is zero (M = 0, which includes the byte value 0x00), no timeout ever occurs, whatever ticks arrive.
- R3: A write (`cfg_wr`) or a read (`cfg_rd`) clears `wd_flag` at the next edge and restarts the count. A write uses the new byte and a read uses the byte already held. A restart wins over a tick or an expiry in the same cycle.
- R4: On expiry, `wd_flag` goes to 1 at the edge of the final tick. The count then stops, and no second expiry occurs until the next restart.
- R5: On expiry with the steering bit at 1, the byte is cleared to 0x00. `reset_req` and `century_clr` are then each high for exactly one cycle, in the cycle right after the final tick's edge.
- R6: On expiry with the steering bit at 0, `irq_pulse` is high for exactly one cycle and the byte is kept.
- R7: The count advances only on cycles where `tick` is 1. Cycles without a tick leave the remaining time unchanged.
- R8: While `rst_n` is 0, the countdown is halted and the pulses are held at 0. `cfg_rdata` and `wd_flag` keep their values. After release, no timeout occurs until the next restart.
- R9: While `por_n` is 0, the byte reads 0x00, `wd_flag` is 0, the pulses are 0 and no countdown runs.
- R10: `irq_pulse` and `reset_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| rst_n | input | 1 | System reset, active low, synchronous; halts the countdown only |
| tick | input | 1 | One-cycle strobe per sixteenth of a second |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_rd | input | 1 | Read strobe for the configuration byte (restarts the count) |
| cfg_wdata | input | 8 | Byte to write |
| cfg_rdata | output | 8 | Configuration byte currently held |
| wd_flag | output | 1 | Timeout flag |
| irq_pulse | output | 1 | One-cycle interrupt on expiry with steering bit 0 |
| reset_req | output | 1 | One-cycle system reset request on expiry with steering bit 1 |
| century_clr | output | 1 | One-cycle request to clear the neighbouring century-style bit |

## Verification
The bench builds the block with its default widths: a five-bit multiplier and a two-bit resolution. With these widths the whole range of intervals can be reached, including the longest one of 1984 ticks, which is covered by a directed run with a tick on every cycle. Random stimulus mostly uses small multipliers and resolutions, so that many expiries, restarts that race a final tick, and ticks that land on load cycles all occur within a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_IRQ   = 2'd1,
    ACT_RESET = 2'd2
  } wd_action_e;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             wipe,
  output logic [CFG_W-1:0] cfg_q
);
  // Only power-on reset touches the byte; system reset leaves it alone.
  always_ff @(posedge clk) begin
    if (!por_n)      cfg_q <= '0;
    else if (wr_en)  cfg_q <= wr_data;
    else if (wipe)   cfg_q <= '0;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = 11
) (
  input  logic                    clk,
  input  logic                    srst_n,
  input  logic                    load,
  input  logic [MULT_W+RES_W-1:0] field,
  input  logic                    tick,
  output logic                    expire_evt,
  output logic                    running
);
  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] span;

  // Interval in ticks: multiplier shifted left by twice the resolution.
  function automatic logic [CNT_W-1:0] interval_ticks(
    input logic [MULT_W-1:0] mult,
    input logic [RES_W-1:0]  res
  );
    logic [CNT_W-1:0] base;
    base = CNT_W'(mult);
    return base << {res, 1'b0};
  endfunction

  assign span       = interval_ticks(field[MULT_W+RES_W-1:RES_W], field[RES_W-1:0]);
  assign expire_evt = srst_n && running && tick && !load && (remain_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!srst_n) begin
      running  <= 1'b0;
      remain_q <= '0;
    end else if (load) begin
      running  <= (span != '0);
      remain_q <= span;
    end else if (expire_evt) begin
      running  <= 1'b0;
      remain_q <= '0;
    end else if (running && tick) begin
      remain_q <= remain_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry (
  input  logic clk,
  input  logic por_n,
  input  logic srst_n,
  input  logic restart,
  input  logic expire_evt,
  input  logic steer,
  output logic flag_q,
  output logic irq_q,
  output logic rst_req_q,
  output logic cent_clr_q
);
  import wdt_pkg::*;

  wd_action_e action;

  always_comb begin
    action = ACT_NONE;
    if (expire_evt) action = steer ? ACT_RESET : ACT_IRQ;
  end

  // The flag survives system reset so software can see why it happened.
  always_ff @(posedge clk) begin
    if (!por_n)          flag_q <= 1'b0;
    else if (restart)    flag_q <= 1'b0;
    else if (expire_evt) flag_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!srst_n) begin
      irq_q      <= 1'b0;
      rst_req_q  <= 1'b0;
      cent_clr_q <= 1'b0;
    end else begin
      irq_q      <= (action == ACT_IRQ);
      rst_req_q  <= (action == ACT_RESET);
      cent_clr_q <= (action == ACT_RESET);
    end
  end
endmodule

// File: rtl/interval_watchdog.sv
module interval_watchdog #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  localparam int CFG_W = MULT_W + RES_W + 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             wd_flag,
  output logic             irq_pulse,
  output logic             reset_req,
  output logic             century_clr
);
  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

  logic             srst_n;
  logic             restart;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] load_cfg;
  logic             expire_evt;
  logic             running;
  logic             steer_reset;

  assign srst_n      = por_n && rst_n;
  assign restart     = cfg_wr || cfg_rd;
  assign load_cfg    = cfg_wr ? cfg_wdata : cfg_q;
  assign steer_reset = expire_evt && cfg_q[CFG_W-1];

  wdt_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .por_n(por_n), .wr_en(cfg_wr), .wr_data(cfg_wdata),
    .wipe(steer_reset), .cfg_q(cfg_q)
  );

  wdt_countdown #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .srst_n(srst_n), .load(restart),
    .field(load_cfg[CFG_W-2:0]), .tick(tick),
    .expire_evt(expire_evt), .running(running)
  );

  wdt_expiry u_exp (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .restart(restart),
    .expire_evt(expire_evt), .steer(cfg_q[CFG_W-1]),
    .flag_q(wd_flag), .irq_q(irq_pulse), .rst_req_q(reset_req),
    .cent_clr_q(century_clr)
  );

  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cfg_rd,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             wd_flag,
  input logic             irq_pulse,
  input logic             reset_req,
  input logic             century_clr,
  input logic             expire_evt,
  input logic             running
);
  assert_never_both_R10: assert property (@(posedge clk) disable iff (!por_n)
    !(irq_pulse && reset_req));

  assert_reset_wipes_cfg_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    reset_req |-> (cfg_rdata == '0) && wd_flag && century_clr);

  assert_reset_single_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    reset_req |=> !reset_req);

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    irq_pulse |=> !irq_pulse);

  assert_irq_sets_flag_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    irq_pulse |-> wd_flag);

  assert_expiry_acts_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    expire_evt |=> (irq_pulse || reset_req));

  assert_expiry_stops_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    expire_evt |=> !running);

  assert_restart_clears_R3: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_wr || cfg_rd) |=> !wd_flag);

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!por_n)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata));

  assert_halt_in_reset_R8: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> !running && !irq_pulse && !reset_req);
endmodule

bind interval_watchdog wdt_checks #(.CFG_W(CFG_W)) u_wdt_checks (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wd_flag(wd_flag),
  .irq_pulse(irq_pulse), .reset_req(reset_req), .century_clr(century_clr),
  .expire_evt(expire_evt), .running(running)
);

// File: tb/test_interval_watchdog.sv
module test_interval_watchdog;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic       cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       wd_flag, irq_pulse, reset_req, century_clr;

  int n_vec = 0, n_bad = 0;

  // Reference state
  logic [7:0] m_cfg = 8'h00;
  bit         m_flag = 0, m_run = 0, m_irq = 0, m_rst = 0;
  int         m_left = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_watchdog i_interval_watchdog (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wd_flag(wd_flag), .irq_pulse(irq_pulse),
    .reset_req(reset_req), .century_clr(century_clr)
  );

  // R1: ticks = M * 4^R, M = bits 6:2, R = bits 1:0
  function automatic int ticks_for(input logic [7:0] v);
    int t;
    t = int'(v[6:2]);
    for (int k = 0; k < int'(v[1:0]); k++) t = t * 4;
    return t;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit wr, input bit rd, input logic [7:0] d,
                      input bit tk, input string tag);
    cfg_wr = wr; cfg_rd = rd; cfg_wdata = d; tick = tk;
    @(posedge clk);
    m_irq = 0; m_rst = 0;
    if (!por_n) begin
      m_cfg = 8'h00; m_flag = 0; m_run = 0; m_left = 0;
    end else begin
      if (wr) m_cfg = d;
      if (wr || rd) m_flag = 0;
      if (!rst_n) begin
        m_run = 0;
      end else if (wr || rd) begin
        m_left = ticks_for(m_cfg);
        m_run  = (m_left != 0);
      end else if (m_run && tk) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_run = 0; m_flag = 1;
          if (m_cfg[7]) begin m_cfg = 8'h00; m_rst = 1; end
          else m_irq = 1;
        end
      end
    end
    #1;
    check(tag, "cfg_rdata", cfg_rdata, m_cfg);
    check(tag, "wd_flag", wd_flag, m_flag);
    check(tag, "irq_pulse", irq_pulse, m_irq);
    check(tag, "reset_req", reset_req, m_rst);
    check(tag, "century_clr", century_clr, m_rst);
    check("R10", "pulse overlap", irq_pulse && reset_req, 0);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD/2 + 1);
    // R9: power-on state, even with writes and ticks attempted
    step(0, 0, 8'h00, 1, "R9");
    step(0, 0, 8'h00, 1, "R9");
    por_n = 1'b1; rst_n = 1'b1;
    step(0, 0, 8'h00, 1, "R9");

    // R1 / R6: M=1,R=1 -> 4 ticks, interrupt steering
    step(1, 0, 8'h05, 0, "R1");
    ticks(3, "R1");
    step(0, 0, 8'h00, 1, "R6");
    step(0, 0, 8'h00, 0, "R6");
    // R4: stopped after expiry
    ticks(40, "R4");

    // R5: M=2,R=0, steering to reset
    step(1, 0, 8'h88, 1, "R5");
    ticks(4, "R5");

    // R2: zero value and zero multiplier disable
    step(1, 0, 8'h00, 0, "R2");
    ticks(60, "R2");
    step(1, 0, 8'h83, 0, "R2");
    ticks(60, "R2");

    // R3: M=2,R=1 -> 8 ticks, read restarts mid-count
    step(1, 0, 8'h09, 0, "R3");
    ticks(5, "R3");
    step(0, 1, 8'h00, 1, "R3");
    ticks(7, "R3");
    // R7: idle cycles hold the count
    for (int i = 0; i < 20; i++) step(0, 0, 8'h00, 0, "R7");
    ticks(1, "R7");
    // R3: restart racing the last tick
    step(1, 0, 8'h04, 0, "R3");
    step(0, 1, 8'h00, 1, "R3");
    ticks(1, "R3");

    // R8: system reset halts, keeps byte and flag
    step(1, 0, 8'h05, 0, "R8");
    ticks(2, "R8");
    rst_n = 1'b0;
    ticks(4, "R8");
    rst_n = 1'b1;
    ticks(20, "R8");

    // R1: longest interval 31*64 with reset steering
    step(1, 0, 8'hFF, 0, "R1");
    ticks(1990, "R1");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [7:0] v;
      op = int'($urandom % 16);
      v  = {1'($urandom % 2), 3'b000, 2'($urandom % 4), 2'($urandom % 2)};
      if (op == 0)      step(1, 0, v, 1'($urandom % 2), "R10");
      else if (op == 1) step(0, 1, 8'h00, 1'($urandom % 2), "R10");
      else              step(0, 0, 8'h00, ($urandom % 3) != 0, "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule